// File: doc/BRIEF.md
# Late-Write Synchronous SRAM With Sleep

This block is a clocked SRAM array with registered command, address and data paths. All inputs are sampled on the rising edge of `clk`. A read latches its address on one edge. Its word leaves the output register after the next edge. A write also latches its address and byte mask on one edge, but it takes its data word from `din` one edge later. This late-write timing lets a bus controller issue commands back to back with no turnaround gap. Each of the four byte lanes has its own active-low select, so a write can touch any subset of lanes.

The data bus is split into `din`, `dout` and a drive-enable `dout_en` that stands in for the pad's tri-state control. A power-down input `zz` puts the array to sleep. The array keeps its contents while asleep. A late write already in flight when `zz` rises still completes. While `zz` is high, and for a recovery window after it falls, commands are refused. Any command refused this way raises the `viol` flag on the following cycle.

Top module: `lwsram_top`

## Requirements
- R1: After synchronous reset, `dout_en` is 0 and `viol` is 0, even with `oen_n` low.
- R2: A read (`cen_n`=0, `wen_n`=1) at edge k drives the word at `addr` on `dout` after edge k+1. Reads may be issued on consecutive edges.
- R3: A write (`cen_n`=0, `wen_n`=0) at edge k stores the value that `din` holds at edge k+1 into `addr`.
- R4: `bsel_n[i]` low enables byte lane i, which is `din`/`dout` bits [8i+7:8i]. Any combination of the four lanes can be written, and unselected lanes keep their old value.
- R5: A write with all four `bsel_n` bits high is an aborted write, and no byte of the array changes.
- R6: After an edge with `cen_n` high and no read data pending, `dout_en` is 0.
- R7: `dout_en` is 1 only in a read-data cycle with `oen_n` low. When `dout_en` is 0, `dout` reads as zero.
- R8: A read issued on the edge that captures a pending write's data, to the same address, returns that write's bytes in its selected lanes and the old bytes in the other lanes.
- R9: A command sampled with `zz` high is ignored, and the array contents stay unchanged through sleep.
- R10: After `zz` is sampled low (edge e), commands at edges e+1 and e+2 are ignored. A command at edge e+3 is accepted.
- R11: A write issued on the edge before `zz` rises still stores its data, which is captured on the edge where `zz` is first high.
- R12: `viol` is 1 in the cycle after any edge at which `cen_n` was low and the command was refused, and 0 after an accepted or deselect edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cen_n | input | 1 | Chip enable, active low |
| wen_n | input | 1 | Write enable, active low |
| bsel_n | input | 4 | Per-lane byte write selects, active low |
| oen_n | input | 1 | Output enable, active low, asynchronous gate |
| addr | input | 6 | Word address |
| din | input | 32 | Write data, sampled one edge after the write command |
| dout | output | 32 | Read data, zero when not driven |
| dout_en | output | 1 | Read data is being driven |
| zz | input | 1 | Sleep request, active high |
| viol | output | 1 | A command was refused on the previous edge |

## Verification
Two events can fall on the same edge. One is a write's late data phase, when its bytes commit to the array. The other is a new read of the same word, which samples the array on that edge. The bench provokes this by issuing a write and then a read of the same address on the next edge, with the write data presented on the read's edge. It does this for several lane masks. It judges the word that reaches `dout` one edge later against a merge computed in the bench: new bytes in the selected lanes, old bytes in the others. The same overlap is provoked at the sleep boundary, where a write's data phase coincides with the first edge that sees `zz` high. A later read after wake-up confirms that the write landed.

// File: rtl/lwsram_pkg.sv
`timescale 1ns/1ps
package lwsram_pkg;

    localparam int ADDR_W_DEF  = 6;
    localparam int LANES_DEF   = 4;
    localparam int LANE_W_DEF  = 8;
    localparam int ENTER_DEF   = 2;
    localparam int WAKE_DEF    = 2;

    typedef enum logic [1:0] {
        PWR_RUN   = 2'd0,
        PWR_DOZE  = 2'd1,
        PWR_SLEEP = 2'd2,
        PWR_WAKE  = 2'd3
    } pwr_e;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } cmd_e;

    function automatic cmd_e decode_cmd(input logic cen_n, input logic wen_n);
        if (cen_n)      return CMD_IDLE;
        else if (wen_n) return CMD_READ;
        else            return CMD_WRITE;
    endfunction

endpackage

// File: rtl/lwsram_ctrl.sv
`timescale 1ns/1ps
module lwsram_ctrl
    import lwsram_pkg::*;
#(
    parameter int ENTER_CYC = ENTER_DEF,
    parameter int WAKE_CYC  = WAKE_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic cen_n,
    input  logic wen_n,
    input  logic zz,
    output logic rd_go,
    output logic wr_go,
    output logic viol
);

    localparam int MAXC = (ENTER_CYC > WAKE_CYC) ? ENTER_CYC : WAKE_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    pwr_e          state;
    logic [CW-1:0] cnt;
    cmd_e          cmd;
    logic          accept;

    assign cmd    = decode_cmd(cen_n, wen_n);
    assign accept = (state == PWR_RUN) && !zz;
    assign rd_go  = accept && (cmd == CMD_READ);
    assign wr_go  = accept && (cmd == CMD_WRITE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PWR_RUN;
            cnt   <= '0;
            viol  <= 1'b0;
        end else begin
            viol <= (cmd != CMD_IDLE) && !accept;
            unique case (state)
                PWR_RUN: begin
                    if (zz) begin
                        state <= PWR_DOZE;
                        cnt   <= '0;
                    end
                end
                PWR_DOZE: begin
                    if (!zz) begin
                        state <= PWR_WAKE;
                        cnt   <= '0;
                    end else if (cnt == CW'(ENTER_CYC - 1)) begin
                        state <= PWR_SLEEP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PWR_SLEEP: begin
                    if (!zz) begin
                        state <= PWR_WAKE;
                        cnt   <= '0;
                    end
                end
                PWR_WAKE: begin
                    if (zz) begin
                        state <= PWR_DOZE;
                        cnt   <= '0;
                    end else if (cnt == CW'(WAKE_CYC - 1)) begin
                        state <= PWR_RUN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= PWR_RUN;
            endcase
        end
    end

    assert_sleep_block_R9: assert property (@(posedge clk) disable iff (rst)
        zz |-> !(rd_go || wr_go));

    assert_wake_block_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(zz) |=> !(rd_go || wr_go));

    assert_viol_flag_R12: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && !rd_go && !wr_go) |=> viol);

endmodule

// File: rtl/lwsram_array.sv
`timescale 1ns/1ps
module lwsram_array
    import lwsram_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int LANES  = LANES_DEF,
    parameter int LANE_W = LANE_W_DEF
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [LANES-1:0]         wmask,
    input  logic [LANES*LANE_W-1:0]  wdata,
    input  logic                     re,
    input  logic [ADDR_W-1:0]        raddr,
    output logic [LANES*LANE_W-1:0]  rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic same_word;
    assign same_word = we && (waddr == raddr);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] wbyte;
        logic [LANE_W-1:0] rq;
        logic              lane_we;

        assign wbyte   = wdata[l*LANE_W +: LANE_W];
        assign lane_we = we && wmask[l];

        always_ff @(posedge clk) begin
            if (lane_we)
                mem[waddr] <= wbyte;
            if (re)
                rq <= (same_word && wmask[l]) ? wbyte : mem[raddr];
        end

        assign rdata[l*LANE_W +: LANE_W] = rq;
    end

endmodule

// File: rtl/lwsram_top.sv
`timescale 1ns/1ps
module lwsram_top
    import lwsram_pkg::*;
#(
    parameter int ADDR_W    = ADDR_W_DEF,
    parameter int LANES     = LANES_DEF,
    parameter int LANE_W    = LANE_W_DEF,
    parameter int ENTER_CYC = ENTER_DEF,
    parameter int WAKE_CYC  = WAKE_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cen_n,
    input  logic                     wen_n,
    input  logic [LANES-1:0]         bsel_n,
    input  logic                     oen_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [LANES*LANE_W-1:0]  din,
    output logic [LANES*LANE_W-1:0]  dout,
    output logic                     dout_en,
    input  logic                     zz,
    output logic                     viol
);

    localparam int DATA_W = LANES * LANE_W;

    logic              rd_go, wr_go;
    logic              wr_pend_q;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [LANES-1:0]  wr_mask_q;
    logic              rd_pend_q;
    logic              out_valid_q;
    logic [DATA_W-1:0] arr_q;
    logic [DATA_W-1:0] dout_q;

    lwsram_ctrl #(
        .ENTER_CYC (ENTER_CYC),
        .WAKE_CYC  (WAKE_CYC)
    ) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .cen_n (cen_n),
        .wen_n (wen_n),
        .zz    (zz),
        .rd_go (rd_go),
        .wr_go (wr_go),
        .viol  (viol)
    );

    lwsram_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_array (
        .clk   (clk),
        .we    (wr_pend_q),
        .waddr (wr_addr_q),
        .wmask (wr_mask_q),
        .wdata (din),
        .re    (rd_go),
        .raddr (addr),
        .rdata (arr_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_pend_q   <= 1'b0;
            rd_pend_q   <= 1'b0;
            out_valid_q <= 1'b0;
        end else begin
            wr_pend_q   <= wr_go;
            rd_pend_q   <= rd_go;
            out_valid_q <= rd_pend_q;
        end
        if (wr_go) begin
            wr_addr_q <= addr;
            wr_mask_q <= ~bsel_n;
        end
        if (rd_pend_q)
            dout_q <= arr_q;
    end

    assign dout_en = out_valid_q && !oen_n;
    assign dout    = dout_en ? dout_q : '0;

    assert_read_latency_R2: assert property (@(posedge clk) disable iff (rst)
        rd_go |=> ##1 out_valid_q);

    assert_deselect_R6: assert property (@(posedge clk) disable iff (rst)
        (cen_n && !rd_pend_q) |=> !out_valid_q);

endmodule

// File: tb/test_lwsram_top.sv
`timescale 1ns/1ps
module test_lwsram_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cen_n, wen_n, oen_n, zz;
    logic [3:0]  bsel_n;
    logic [5:0]  addr;
    logic [31:0] din;
    logic [31:0] dout;
    logic        dout_en;
    logic        viol;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [31:0] ref_m [64];

    always #2.5 clk = ~clk;

    lwsram_top i_lwsram_top (
        .clk     (clk),
        .rst     (rst),
        .cen_n   (cen_n),
        .wen_n   (wen_n),
        .bsel_n  (bsel_n),
        .oen_n   (oen_n),
        .addr    (addr),
        .din     (din),
        .dout    (dout),
        .dout_en (dout_en),
        .zz      (zz),
        .viol    (viol)
    );

    function automatic logic [31:0] pat(input int i);
        return (32'h9E3779B9 * (i + 1)) ^ 32'(i);
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] m);
        logic [31:0] r;
        for (int l = 0; l < 4; l++)
            r[l*8 +: 8] = m[l] ? nw[l*8 +: 8] : old[l*8 +: 8];
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step(input logic c, input logic w, input logic [3:0] bs,
                        input logic [5:0] a, input logic [31:0] d, input logic z);
        @(negedge clk);
        cen_n = c; wen_n = w; bsel_n = bs; addr = a; din = d; zz = z;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cen_n = 1'b1; wen_n = 1'b1; bsel_n = 4'hF; oen_n = 1'b0;
        addr = '0; din = '0; zz = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        // R1: reset state with output enable asserted
        chk("R1 dout_en", 32'(dout_en), 32'd0);
        chk("R1 viol", 32'(viol), 32'd0);

        // R3: back-to-back writes with late data across the whole array
        for (int i = 0; i <= 64; i++) begin
            step(i < 64 ? 1'b0 : 1'b1, 1'b0, 4'h0, 6'(i), i > 0 ? pat(i - 1) : 32'h0, 1'b0);
            if (i > 0) ref_m[i - 1] = pat(i - 1);
        end

        // R2: back-to-back reads, data one edge after the address edge
        for (int i = 0; i <= 64; i++) begin
            step(i < 64 ? 1'b0 : 1'b1, 1'b1, 4'hF, 6'(i), 32'h0, 1'b0);
            if (i > 0) begin
                chk("R2 dout_en", 32'(dout_en), 32'd1);
                chk("R3/R2 data", dout, ref_m[i - 1]);
            end
        end
        // R6: deselect edge with nothing pending disables output
        step(1'b1, 1'b1, 4'hF, 6'd0, 32'h0, 1'b0);
        chk("R6 dout_en", 32'(dout_en), 32'd0);
        chk("R7 dout zero", dout, 32'h0);

        // R7: output enable gating
        step(1'b0, 1'b1, 4'hF, 6'd10, 32'h0, 1'b0);
        step(1'b1, 1'b1, 4'hF, 6'd0, 32'h0, 1'b0);
        oen_n = 1'b1; #1;
        chk("R7 oe high dout_en", 32'(dout_en), 32'd0);
        chk("R7 oe high dout", dout, 32'h0);
        oen_n = 1'b0; #1;
        chk("R7 oe low dout_en", 32'(dout_en), 32'd1);
        chk("R7 oe low dout", dout, ref_m[10]);

        // R4, R5: every lane mask, including the abort with all selects high
        for (int m = 0; m < 16; m++) begin
            logic [31:0] d;
            d = 32'h01020304 * 32'(m + 3);
            step(1'b0, 1'b0, ~4'(m), 6'd5, 32'h0, 1'b0);
            step(1'b1, 1'b1, 4'hF, 6'd0, d, 1'b0);
            ref_m[5] = merge(ref_m[5], d, 4'(m));
            step(1'b0, 1'b1, 4'hF, 6'd5, 32'h0, 1'b0);
            step(1'b1, 1'b1, 4'hF, 6'd0, 32'h0, 1'b0);
            chk(m == 0 ? "R5 abort keeps word" : "R4 lane mask", dout, ref_m[5]);
        end

        // R8: read on the edge where the pending write commits, same address
        for (int k = 0; k < 4; k++) begin
            logic [3:0]  m;
            logic [31:0] d;
            m = (k == 0) ? 4'h5 : (k == 1) ? 4'hA : (k == 2) ? 4'hF : 4'h3;
            d = pat(100 + k);
            step(1'b0, 1'b0, ~m, 6'd9, 32'h0, 1'b0);
            step(1'b0, 1'b1, 4'hF, 6'd9, d, 1'b0);
            ref_m[9] = merge(ref_m[9], d, m);
            step(1'b1, 1'b1, 4'hF, 6'd0, 32'h0, 1'b0);
            chk("R8 forwarded read", dout, ref_m[9]);
        end

        // R11: write whose data edge sees zz high still lands
        step(1'b0, 1'b0, 4'h0, 6'd7, 32'h0, 1'b0);
        step(1'b1, 1'b1, 4'hF, 6'd0, 32'h7777_1234, 1'b1);
        ref_m[7] = 32'h7777_1234;
        chk("R12 no viol on deselect", 32'(viol), 32'd0);
        // R9: commands while asleep are refused
        step(1'b0, 1'b1, 4'hF, 6'd3, 32'h0, 1'b1);
        chk("R12 viol read in sleep", 32'(viol), 32'd1);
        step(1'b0, 1'b0, 4'h0, 6'd3, 32'h0, 1'b1);
        chk("R9 read ignored", 32'(dout_en), 32'd0);
        chk("R12 viol write in sleep", 32'(viol), 32'd1);
        step(1'b1, 1'b1, 4'hF, 6'd0, 32'hDEAD_BEEF, 1'b1);
        step(1'b1, 1'b1, 4'hF, 6'd0, 32'h0, 1'b1);
        step(1'b1, 1'b1, 4'hF, 6'd0, 32'h0, 1'b1);
        // R10: edge e (zz low), then e+1 and e+2 refused, e+3 accepted
        step(1'b1, 1'b1, 4'hF, 6'd0, 32'h0, 1'b0);
        step(1'b0, 1'b0, 4'h0, 6'd3, 32'h0, 1'b0);
        chk("R10 e+1 refused", 32'(viol), 32'd1);
        step(1'b0, 1'b0, 4'h0, 6'd3, 32'hBAD0_0001, 1'b0);
        chk("R10 e+2 refused", 32'(viol), 32'd1);
        step(1'b0, 1'b0, 4'h0, 6'd4, 32'hBAD0_0002, 1'b0);
        chk("R10 e+3 accepted", 32'(viol), 32'd0);
        step(1'b0, 1'b1, 4'hF, 6'd3, 32'h4444_ABCD, 1'b0);
        ref_m[4] = 32'h4444_ABCD;
        step(1'b0, 1'b1, 4'hF, 6'd4, 32'h0, 1'b0);
        chk("R9 contents kept", dout, ref_m[3]);
        step(1'b0, 1'b1, 4'hF, 6'd7, 32'h0, 1'b0);
        chk("R10 write after recovery", dout, ref_m[4]);
        step(1'b1, 1'b1, 4'hF, 6'd0, 32'h0, 1'b0);
        chk("R11 pending write landed", dout, ref_m[7]);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule